// File: doc/BRIEF.md
# Index-Linked Doubly Linked List Engine

This block keeps a set of doubly linked lists in hardware. The nodes sit in an on-chip array of fixed-size records. Each record is eight 32-bit words, and a node's base word address is its index times eight. A link is a 16-bit node index, not a full pointer. The value 0xFFFF means "no node". One record holds several link pairs. A node can therefore sit in a parent-child chain and a sibling chain at the same time. List `L` uses link pair `L % LINK_PAIRS`, which is stored in word `L % LINK_PAIRS` of the record. Within that word, the next link is in bits [15:0] and the previous link is in bits [31:16]. The other words of the record belong to the user, and the engine never touches them.

A client sends one command at a time on a valid/ready port. Each command names an operation, a list, a node and, for an insert-after, a reference node. Each list has a head register and a tail register. The engine makes at most one node-memory access per cycle and updates those registers as it goes. When a command ends, the engine returns a single-cycle response carrying a status code, a link value and a tail value.

Operation codes on `cmd_op`:

| Code | Operation |
|---|---|
| 0 | push at head |
| 1 | push at tail |
| 2 | insert after reference |
| 3 | remove |
| 4 | step to next |
| 5 | step to previous |
| 6 | query ends |
| 7 | reserved |

Status codes on `rsp_status`:

| Code | Meaning |
|---|---|
| 0 | ok |
| 1 | index out of range |
| 2 | list empty |
| 3 | unknown operation |

Top module: `llist_engine`

## Requirements
- R1: After reset, a query (op 6) of any list returns status 0 with `rsp_link` (head) and `rsp_tail` (tail) both 0xFFFF.
- R2: Push at head (op 0) on an empty list makes the node both head and tail, with both of its links 0xFFFF. On a non-empty list, the node becomes head, its next link is the old head, its previous link is 0xFFFF, and the old head's previous link becomes the node.
- R3: Push at tail (op 1) mirrors R2. The node becomes tail, its previous link is the old tail, and the old tail's next link becomes the node. On an empty list, the node becomes both head and tail.
- R4: Insert after (op 2) places the node between the reference and the reference's successor, and relinks both neighbours. If the reference was the tail, the node becomes the new tail.
- R5: Remove (op 3) joins the node's predecessor and successor directly. If the node was the head, the head register moves to the successor. If it was the tail, the tail register moves to the predecessor. Removing the last node leaves both registers at 0xFFFF.
- R6: Step next (op 4) and step previous (op 5) return, in `rsp_link`, the next or previous link of the node in the named list's link pair. At the end of the list this value is 0xFFFF.
- R7: A node index, or for op 2 a reference index, of NUM_NODES or more (0xFFFF included) returns status 1 and changes neither memory nor any head or tail register. This range check takes precedence over the empty check.
- R8: Remove or insert-after on an empty list returns status 2 and changes nothing.
- R9: Lists mapped to different link pairs are independent. One node may hold different positions in two such lists at once.
- R10: No command makes more than four node-memory accesses. An insert's response appears no later than the fifth clock cycle after the command is accepted.
- R11: `cmd_ready` is low while a command is in progress. Each accepted command produces exactly one response, and `rsp_valid` is high for a single cycle.
- R12: Op code 7 returns status 3 and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine idle and able to take a command |
| cmd_op | input | 3 | Operation code |
| cmd_list | input | LIST_W | List selector |
| cmd_node | input | 16 | Node index operated on |
| cmd_ref | input | 16 | Reference node for insert-after |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_status | output | 2 | Status code |
| rsp_link | output | 16 | Step result or list head |
| rsp_tail | output | 16 | List tail (query), else 0xFFFF |

## Verification
The case that is hardest to reach is an insert-after whose reference has a successor. It needs a read, then three writes, with the successor index held across cycles, so it is the only path that uses the full four-access budget. The bench first builds a list through its ports with head and tail pushes. It then inserts in the middle and times the response. Removal of the head, the tail and the last remaining node is reached by draining that list through its ports, and the bench checks every neighbour link by stepping. The same node is placed in two lists that use different link pairs, in opposite orders, to show the pairs do not interfere.

// File: rtl/llist_pkg.sv
`timescale 1ns/1ps
package llist_pkg;

    localparam int IDX_W     = 16;
    localparam int REC_WORDS = 8;
    localparam int WSEL_W    = $clog2(REC_WORDS);

    typedef logic [IDX_W-1:0] idx_t;

    localparam idx_t NIL = 16'hFFFF;

    // One link word of a record: prev in the upper half, next in the lower half
    typedef struct packed {
        idx_t prev;
        idx_t next;
    } link_word_t;

    typedef enum logic [2:0] {
        OP_PUSH_HEAD = 3'd0,
        OP_PUSH_TAIL = 3'd1,
        OP_INS_AFTER = 3'd2,
        OP_REMOVE    = 3'd3,
        OP_STEP_NEXT = 3'd4,
        OP_STEP_PREV = 3'd5,
        OP_QUERY     = 3'd6,
        OP_RESERVED  = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        STS_OK    = 2'd0,
        STS_RANGE = 2'd1,
        STS_EMPTY = 2'd2,
        STS_BADOP = 2'd3
    } status_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_A,
        SQ_B,
        SQ_C,
        SQ_D
    } seq_st_e;

    function automatic logic idx_ok(idx_t i, int limit);
        return int'(i) < limit;
    endfunction

    function automatic link_word_t mk_word(idx_t p, idx_t n);
        link_word_t w;
        w.prev = p;
        w.next = n;
        return w;
    endfunction

endpackage

// File: rtl/llist_node_mem.sv
`timescale 1ns/1ps
module llist_node_mem
    import llist_pkg::*;
#(
    parameter int NUM_NODES = 64,
    localparam int NODE_AW = $clog2(NUM_NODES),
    localparam int AW      = NODE_AW + WSEL_W,
    localparam int DEPTH   = NUM_NODES * REC_WORDS
) (
    input  logic          clk,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output link_word_t    rd_data,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic          wr_lo,
    input  logic          wr_hi,
    input  link_word_t    wr_data
);

    logic [2*IDX_W-1:0] store [DEPTH];
    link_word_t         rd_q;

    // Half-word enables let one write update a single link without a read
    always_ff @(posedge clk) begin
        if (wr_en) begin
            if (wr_lo) store[wr_addr][IDX_W-1:0]       <= wr_data.next;
            if (wr_hi) store[wr_addr][2*IDX_W-1:IDX_W] <= wr_data.prev;
        end
        if (rd_en) rd_q <= link_word_t'(store[rd_addr]);
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/llist_ends.sv
`timescale 1ns/1ps
module llist_ends
    import llist_pkg::*;
#(
    parameter int NUM_LISTS = 4,
    localparam int LIST_W = (NUM_LISTS > 1) ? $clog2(NUM_LISTS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LIST_W-1:0] sel,
    output idx_t              head,
    output idx_t              tail,
    input  logic              head_we,
    input  idx_t              head_val,
    input  logic              tail_we,
    input  idx_t              tail_val
);

    idx_t head_r [NUM_LISTS];
    idx_t tail_r [NUM_LISTS];

    for (genvar g = 0; g < NUM_LISTS; g++) begin : g_list
        always_ff @(posedge clk) begin
            if (rst) begin
                head_r[g] <= NIL;
                tail_r[g] <= NIL;
            end else begin
                if (head_we && (int'(sel) == g)) head_r[g] <= head_val;
                if (tail_we && (int'(sel) == g)) tail_r[g] <= tail_val;
            end
        end

        // R5: head and tail become empty and non-empty together
        a_r5_ends_agree: assert property (@(posedge clk) disable iff (rst)
            (head_r[g] == NIL) == (tail_r[g] == NIL));
    end

    assign head = head_r[sel];
    assign tail = tail_r[sel];

endmodule

// File: rtl/llist_seq.sv
`timescale 1ns/1ps
module llist_seq
    import llist_pkg::*;
#(
    parameter int NUM_NODES  = 64,
    parameter int NUM_LISTS  = 4,
    parameter int LINK_PAIRS = 2,
    localparam int LIST_W  = (NUM_LISTS > 1) ? $clog2(NUM_LISTS) : 1,
    localparam int NODE_AW = $clog2(NUM_NODES),
    localparam int AW      = NODE_AW + WSEL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [2:0]        cmd_op,
    input  logic [LIST_W-1:0] cmd_list,
    input  idx_t              cmd_node,
    input  idx_t              cmd_ref,
    output logic              rsp_valid,
    output logic [1:0]        rsp_status,
    output idx_t              rsp_link,
    output idx_t              rsp_tail,
    output logic [LIST_W-1:0] end_sel,
    input  idx_t              head_rd,
    input  idx_t              tail_rd,
    output logic              hd_we,
    output idx_t              hd_val,
    output logic              tl_we,
    output idx_t              tl_val,
    output logic              mem_re,
    output logic [AW-1:0]     mem_raddr,
    input  link_word_t        mem_rdata,
    output logic              mem_we,
    output logic [AW-1:0]     mem_waddr,
    output logic              mem_wlo,
    output logic              mem_whi,
    output link_word_t        mem_wdata
);

    seq_st_e           st_q, st_d;
    op_e               op_q;
    logic [LIST_W-1:0] list_q;
    idx_t              node_q, ref_q;
    idx_t              nbr_q, nbr_d;
    idx_t              xp_q, xp_d, xn_q, xn_d;
    logic              accept, done;
    status_e           sts_d;
    idx_t              lnk_d, tl_d;
    logic [WSEL_W-1:0] pair_sel;

    logic              rsp_valid_q;
    status_e           rsp_status_q;
    idx_t              rsp_link_q, rsp_tail_q;

    assign pair_sel  = WSEL_W'(int'(list_q) % LINK_PAIRS);
    assign cmd_ready = (st_q == SQ_IDLE);
    assign end_sel   = (st_q == SQ_IDLE) ? cmd_list : list_q;

    function automatic logic [AW-1:0] rec_addr(idx_t n, logic [WSEL_W-1:0] p);
        return {n[NODE_AW-1:0], p};
    endfunction

    always_comb begin
        st_d      = st_q;
        accept    = 1'b0;
        done      = 1'b0;
        sts_d     = STS_OK;
        lnk_d     = NIL;
        tl_d      = NIL;
        nbr_d     = nbr_q;
        xp_d      = xp_q;
        xn_d      = xn_q;
        mem_re    = 1'b0;
        mem_raddr = rec_addr(node_q, pair_sel);
        mem_we    = 1'b0;
        mem_waddr = rec_addr(node_q, pair_sel);
        mem_wlo   = 1'b0;
        mem_whi   = 1'b0;
        mem_wdata = mk_word(NIL, NIL);
        hd_we     = 1'b0;
        hd_val    = node_q;
        tl_we     = 1'b0;
        tl_val    = node_q;

        unique case (st_q)
            SQ_IDLE: begin
                if (cmd_valid) begin
                    accept = 1'b1;
                    st_d   = SQ_A;
                    unique case (op_e'(cmd_op))
                        OP_PUSH_HEAD, OP_PUSH_TAIL, OP_STEP_NEXT, OP_STEP_PREV: begin
                            if (!idx_ok(cmd_node, NUM_NODES)) begin
                                done = 1'b1; sts_d = STS_RANGE;
                            end
                        end
                        OP_INS_AFTER: begin
                            if (!idx_ok(cmd_node, NUM_NODES) || !idx_ok(cmd_ref, NUM_NODES)) begin
                                done = 1'b1; sts_d = STS_RANGE;
                            end else if (head_rd == NIL) begin
                                done = 1'b1; sts_d = STS_EMPTY;
                            end
                        end
                        OP_REMOVE: begin
                            if (!idx_ok(cmd_node, NUM_NODES)) begin
                                done = 1'b1; sts_d = STS_RANGE;
                            end else if (head_rd == NIL) begin
                                done = 1'b1; sts_d = STS_EMPTY;
                            end
                        end
                        OP_QUERY: begin
                            done  = 1'b1;
                            lnk_d = head_rd;
                            tl_d  = tail_rd;
                        end
                        default: begin
                            done = 1'b1; sts_d = STS_BADOP;
                        end
                    endcase
                    if (done) st_d = SQ_IDLE;
                end
            end

            SQ_A: begin
                unique case (op_q)
                    OP_PUSH_HEAD: begin
                        mem_we = 1'b1; mem_wlo = 1'b1; mem_whi = 1'b1;
                        mem_wdata = mk_word(NIL, head_rd);
                        if (head_rd == NIL) begin
                            hd_we = 1'b1; tl_we = 1'b1; done = 1'b1; st_d = SQ_IDLE;
                        end else begin
                            st_d = SQ_B;
                        end
                    end
                    OP_PUSH_TAIL: begin
                        mem_we = 1'b1; mem_wlo = 1'b1; mem_whi = 1'b1;
                        mem_wdata = mk_word(tail_rd, NIL);
                        if (tail_rd == NIL) begin
                            hd_we = 1'b1; tl_we = 1'b1; done = 1'b1; st_d = SQ_IDLE;
                        end else begin
                            st_d = SQ_B;
                        end
                    end
                    OP_INS_AFTER: begin
                        mem_re    = 1'b1;
                        mem_raddr = rec_addr(ref_q, pair_sel);
                        st_d      = SQ_B;
                    end
                    default: begin
                        mem_re = 1'b1;
                        st_d   = SQ_B;
                    end
                endcase
            end

            SQ_B: begin
                unique case (op_q)
                    OP_PUSH_HEAD: begin
                        mem_we = 1'b1; mem_whi = 1'b1;
                        mem_waddr = rec_addr(head_rd, pair_sel);
                        mem_wdata = mk_word(node_q, NIL);
                        hd_we = 1'b1; done = 1'b1; st_d = SQ_IDLE;
                    end
                    OP_PUSH_TAIL: begin
                        mem_we = 1'b1; mem_wlo = 1'b1;
                        mem_waddr = rec_addr(tail_rd, pair_sel);
                        mem_wdata = mk_word(NIL, node_q);
                        tl_we = 1'b1; done = 1'b1; st_d = SQ_IDLE;
                    end
                    OP_INS_AFTER: begin
                        mem_we = 1'b1; mem_wlo = 1'b1; mem_whi = 1'b1;
                        mem_wdata = mk_word(ref_q, mem_rdata.next);
                        nbr_d = mem_rdata.next;
                        st_d  = SQ_C;
                    end
                    OP_REMOVE: begin
                        xp_d = mem_rdata.prev;
                        xn_d = mem_rdata.next;
                        if (mem_rdata.prev != NIL) begin
                            mem_we = 1'b1; mem_wlo = 1'b1;
                            mem_waddr = rec_addr(mem_rdata.prev, pair_sel);
                            mem_wdata = mk_word(NIL, mem_rdata.next);
                        end
                        st_d = SQ_C;
                    end
                    OP_STEP_NEXT: begin
                        lnk_d = mem_rdata.next; done = 1'b1; st_d = SQ_IDLE;
                    end
                    default: begin
                        lnk_d = mem_rdata.prev; done = 1'b1; st_d = SQ_IDLE;
                    end
                endcase
            end

            SQ_C: begin
                if (op_q == OP_INS_AFTER) begin
                    mem_we = 1'b1; mem_wlo = 1'b1;
                    mem_waddr = rec_addr(ref_q, pair_sel);
                    mem_wdata = mk_word(NIL, node_q);
                    if (nbr_q == NIL) begin
                        tl_we = 1'b1; done = 1'b1; st_d = SQ_IDLE;
                    end else begin
                        st_d = SQ_D;
                    end
                end else begin
                    // Both end registers change in this one cycle
                    if (xp_q == NIL) begin
                        hd_we = 1'b1; hd_val = xn_q;
                    end
                    if (xn_q != NIL) begin
                        mem_we = 1'b1; mem_whi = 1'b1;
                        mem_waddr = rec_addr(xn_q, pair_sel);
                        mem_wdata = mk_word(xp_q, NIL);
                    end else begin
                        tl_we = 1'b1; tl_val = xp_q;
                    end
                    done = 1'b1; st_d = SQ_IDLE;
                end
            end

            default: begin
                mem_we = 1'b1; mem_whi = 1'b1;
                mem_waddr = rec_addr(nbr_q, pair_sel);
                mem_wdata = mk_word(node_q, NIL);
                done = 1'b1; st_d = SQ_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q         <= SQ_IDLE;
            op_q         <= OP_QUERY;
            list_q       <= '0;
            node_q       <= NIL;
            ref_q        <= NIL;
            nbr_q        <= NIL;
            xp_q         <= NIL;
            xn_q         <= NIL;
            rsp_valid_q  <= 1'b0;
            rsp_status_q <= STS_OK;
            rsp_link_q   <= NIL;
            rsp_tail_q   <= NIL;
        end else begin
            st_q        <= st_d;
            nbr_q       <= nbr_d;
            xp_q        <= xp_d;
            xn_q        <= xn_d;
            rsp_valid_q <= done;
            if (accept) begin
                op_q   <= op_e'(cmd_op);
                list_q <= cmd_list;
                node_q <= cmd_node;
                ref_q  <= cmd_ref;
            end
            if (done) begin
                rsp_status_q <= sts_d;
                rsp_link_q   <= lnk_d;
                rsp_tail_q   <= tl_d;
            end
        end
    end

    assign rsp_valid  = rsp_valid_q;
    assign rsp_status = rsp_status_q;
    assign rsp_link   = rsp_link_q;
    assign rsp_tail   = rsp_tail_q;

    // Checker state: memory accesses since acceptance, and an open command flag
    logic [2:0] acc_cnt;
    logic       open_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            acc_cnt <= '0;
            open_q  <= 1'b0;
        end else begin
            if (cmd_valid && cmd_ready) acc_cnt <= '0;
            else if ((mem_re || mem_we) && acc_cnt != 3'd7) acc_cnt <= acc_cnt + 3'd1;
            open_q <= (open_q && !rsp_valid) || (cmd_valid && cmd_ready);
        end
    end

    a_r10_access_budget: assert property (@(posedge clk) disable iff (rst)
        (mem_re || mem_we) |-> (acc_cnt < 3'd4));

    a_r11_rsp_has_cmd: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> open_q);

    a_r11_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
        (mem_re || mem_we) |-> !cmd_ready);

    a_r7_err_no_write: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_status != STS_OK) |-> !$past(mem_we));

endmodule

// File: rtl/llist_engine.sv
`timescale 1ns/1ps
module llist_engine
    import llist_pkg::*;
#(
    parameter int NUM_NODES  = 64,
    parameter int NUM_LISTS  = 4,
    parameter int LINK_PAIRS = 2,
    localparam int LIST_W  = (NUM_LISTS > 1) ? $clog2(NUM_LISTS) : 1,
    localparam int NODE_AW = $clog2(NUM_NODES),
    localparam int AW      = NODE_AW + WSEL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [2:0]        cmd_op,
    input  logic [LIST_W-1:0] cmd_list,
    input  logic [15:0]       cmd_node,
    input  logic [15:0]       cmd_ref,
    output logic              rsp_valid,
    output logic [1:0]        rsp_status,
    output logic [15:0]       rsp_link,
    output logic [15:0]       rsp_tail
);

    logic [LIST_W-1:0] end_sel;
    idx_t              head_rd, tail_rd, hd_val, tl_val;
    logic              hd_we, tl_we;
    logic              mem_re, mem_we, mem_wlo, mem_whi;
    logic [AW-1:0]     mem_raddr, mem_waddr;
    link_word_t        mem_rdata, mem_wdata;

    llist_seq #(
        .NUM_NODES (NUM_NODES),
        .NUM_LISTS (NUM_LISTS),
        .LINK_PAIRS(LINK_PAIRS)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .cmd_op    (cmd_op),
        .cmd_list  (cmd_list),
        .cmd_node  (cmd_node),
        .cmd_ref   (cmd_ref),
        .rsp_valid (rsp_valid),
        .rsp_status(rsp_status),
        .rsp_link  (rsp_link),
        .rsp_tail  (rsp_tail),
        .end_sel   (end_sel),
        .head_rd   (head_rd),
        .tail_rd   (tail_rd),
        .hd_we     (hd_we),
        .hd_val    (hd_val),
        .tl_we     (tl_we),
        .tl_val    (tl_val),
        .mem_re    (mem_re),
        .mem_raddr (mem_raddr),
        .mem_rdata (mem_rdata),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_wlo   (mem_wlo),
        .mem_whi   (mem_whi),
        .mem_wdata (mem_wdata)
    );

    llist_ends #(.NUM_LISTS(NUM_LISTS)) u_ends (
        .clk     (clk),
        .rst     (rst),
        .sel     (end_sel),
        .head    (head_rd),
        .tail    (tail_rd),
        .head_we (hd_we),
        .head_val(hd_val),
        .tail_we (tl_we),
        .tail_val(tl_val)
    );

    llist_node_mem #(.NUM_NODES(NUM_NODES)) u_mem (
        .clk    (clk),
        .rd_en  (mem_re),
        .rd_addr(mem_raddr),
        .rd_data(mem_rdata),
        .wr_en  (mem_we),
        .wr_addr(mem_waddr),
        .wr_lo  (mem_wlo),
        .wr_hi  (mem_whi),
        .wr_data(mem_wdata)
    );

endmodule

// File: tb/test_llist_engine.sv
`timescale 1ns/1ps
module test_llist_engine;

    localparam logic [15:0] NL = 16'hFFFF;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic        cmd_ready;
    logic [2:0]  cmd_op;
    logic [1:0]  cmd_list;
    logic [15:0] cmd_node, cmd_ref;
    logic        rsp_valid;
    logic [1:0]  rsp_status;
    logic [15:0] rsp_link, rsp_tail;

    int checks = 0;
    int errors = 0;

    logic [1:0]  r_sts;
    logic [15:0] r_link, r_tail;
    int          r_cyc;

    always #2 clk = ~clk;

    llist_engine i_llist_engine (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .cmd_op    (cmd_op),
        .cmd_list  (cmd_list),
        .cmd_node  (cmd_node),
        .cmd_ref   (cmd_ref),
        .rsp_valid (rsp_valid),
        .rsp_status(rsp_status),
        .rsp_link  (rsp_link),
        .rsp_tail  (rsp_tail)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run(input logic [2:0] op, input logic [1:0] lst,
                       input logic [15:0] nd, input logic [15:0] rf);
        int guard = 0;
        while (!cmd_ready && guard < 20) begin
            @(negedge clk);
            guard++;
        end
        cmd_op = op; cmd_list = lst; cmd_node = nd; cmd_ref = rf;
        cmd_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        r_cyc = 1;
        if (!rsp_valid) chk("R11 ready low while busy", cmd_ready, 1'b0);
        while (!rsp_valid && r_cyc < 20) begin
            @(negedge clk);
            r_cyc++;
        end
        chk("R11 response arrives", rsp_valid, 1'b1);
        r_sts = rsp_status; r_link = rsp_link; r_tail = rsp_tail;
        @(negedge clk);
        chk("R11 response lasts one cycle", rsp_valid, 1'b0);
    endtask

    task automatic ends_are(input string req, input logic [1:0] lst,
                            input logic [15:0] h, input logic [15:0] t);
        run(3'd6, lst, 16'd0, 16'd0);
        chk({req, " query status"}, r_sts, 2'd0);
        chk({req, " head"}, r_link, h);
        chk({req, " tail"}, r_tail, t);
    endtask

    task automatic link_is(input string req, input logic [1:0] lst, input logic [15:0] nd,
                           input logic dir_prev, input logic [15:0] exp);
        run(dir_prev ? 3'd5 : 3'd4, lst, nd, 16'd0);
        chk({req, " step status"}, r_sts, 2'd0);
        chk({req, " step link"}, r_link, exp);
    endtask

    task automatic t_reset;
        chk("R11 ready after reset", cmd_ready, 1'b1);
        chk("R11 no response after reset", rsp_valid, 1'b0);
        for (int l = 0; l < 4; l++) ends_are("R1 reset ends", 2'(l), NL, NL);
    endtask

    task automatic t_push_head;
        run(3'd0, 2'd0, 16'd5, 16'd0);
        chk("R2 push empty status", r_sts, 2'd0);
        ends_are("R2 push empty", 2'd0, 16'd5, 16'd5);
        link_is("R2 lone next", 2'd0, 16'd5, 1'b0, NL);
        link_is("R2 lone prev", 2'd0, 16'd5, 1'b1, NL);
        run(3'd0, 2'd0, 16'd9, 16'd0);
        chk("R10 push head cycles", 32'(r_cyc <= 5), 1);
        ends_are("R2 push nonempty", 2'd0, 16'd9, 16'd5);
        link_is("R2 new head next", 2'd0, 16'd9, 1'b0, 16'd5);
        link_is("R2 new head prev", 2'd0, 16'd9, 1'b1, NL);
        link_is("R2 old head prev", 2'd0, 16'd5, 1'b1, 16'd9);
    endtask

    task automatic t_push_tail;
        run(3'd1, 2'd0, 16'd12, 16'd0);
        chk("R3 push tail status", r_sts, 2'd0);
        chk("R10 push tail cycles", 32'(r_cyc <= 5), 1);
        ends_are("R3 push tail", 2'd0, 16'd9, 16'd12);
        link_is("R3 old tail next", 2'd0, 16'd5, 1'b0, 16'd12);
        link_is("R3 new tail prev", 2'd0, 16'd12, 1'b1, 16'd5);
        link_is("R3 new tail next", 2'd0, 16'd12, 1'b0, NL);
        run(3'd1, 2'd3, 16'd33, 16'd0);
        ends_are("R3 push tail empty list", 2'd3, 16'd33, 16'd33);
    endtask

    task automatic t_insert_after;
        // list 0 is 9,5,12
        run(3'd2, 2'd0, 16'd7, 16'd9);
        chk("R4 insert middle status", r_sts, 2'd0);
        chk("R10 insert middle cycles", 32'(r_cyc <= 5), 1);
        link_is("R4 ref next", 2'd0, 16'd9, 1'b0, 16'd7);
        link_is("R4 new prev", 2'd0, 16'd7, 1'b1, 16'd9);
        link_is("R4 new next", 2'd0, 16'd7, 1'b0, 16'd5);
        link_is("R4 succ prev", 2'd0, 16'd5, 1'b1, 16'd7);
        run(3'd2, 2'd0, 16'd20, 16'd12);
        chk("R10 insert at tail cycles", 32'(r_cyc <= 5), 1);
        ends_are("R4 insert after tail", 2'd0, 16'd9, 16'd20);
        link_is("R4 tail next", 2'd0, 16'd20, 1'b0, NL);
        link_is("R4 tail prev", 2'd0, 16'd20, 1'b1, 16'd12);
    endtask

    task automatic t_walk;
        logic [15:0] fwd [5] = '{16'd9, 16'd7, 16'd5, 16'd12, 16'd20};
        logic [15:0] cur;
        run(3'd6, 2'd0, 16'd0, 16'd0);
        cur = r_link;
        for (int i = 0; i < 5; i++) begin
            chk("R6 forward order", cur, fwd[i]);
            run(3'd4, 2'd0, cur, 16'd0);
            cur = r_link;
        end
        chk("R6 forward end", cur, NL);
        cur = 16'd20;
        for (int i = 4; i >= 0; i--) begin
            chk("R6 backward order", cur, fwd[i]);
            run(3'd5, 2'd0, cur, 16'd0);
            cur = r_link;
        end
        chk("R6 backward end", cur, NL);
    endtask

    task automatic t_remove;
        run(3'd3, 2'd0, 16'd5, 16'd0);
        chk("R5 remove middle status", r_sts, 2'd0);
        link_is("R5 pred next", 2'd0, 16'd7, 1'b0, 16'd12);
        link_is("R5 succ prev", 2'd0, 16'd12, 1'b1, 16'd7);
        run(3'd3, 2'd0, 16'd9, 16'd0);
        ends_are("R5 remove head", 2'd0, 16'd7, 16'd20);
        link_is("R5 new head prev", 2'd0, 16'd7, 1'b1, NL);
        run(3'd3, 2'd0, 16'd20, 16'd0);
        ends_are("R5 remove tail", 2'd0, 16'd7, 16'd12);
        link_is("R5 new tail next", 2'd0, 16'd12, 1'b0, NL);
        run(3'd3, 2'd0, 16'd7, 16'd0);
        run(3'd3, 2'd0, 16'd12, 16'd0);
        chk("R5 remove last status", r_sts, 2'd0);
        ends_are("R5 list drained", 2'd0, NL, NL);
    endtask

    task automatic t_errors;
        run(3'd0, 2'd2, 16'd30, 16'd0);
        run(3'd3, 2'd2, 16'd200, 16'd0);
        chk("R7 remove out of range", r_sts, 2'd1);
        run(3'd0, 2'd2, 16'd64, 16'd0);
        chk("R7 push index 64", r_sts, 2'd1);
        run(3'd1, 2'd2, NL, 16'd0);
        chk("R7 push null index", r_sts, 2'd1);
        run(3'd2, 2'd2, 16'd31, 16'd100);
        chk("R7 bad reference", r_sts, 2'd1);
        ends_are("R7 ends unchanged", 2'd2, 16'd30, 16'd30);
        link_is("R7 links unchanged", 2'd2, 16'd30, 1'b0, NL);
        run(3'd3, 2'd1, 16'd70, 16'd0);
        chk("R7 range before empty", r_sts, 2'd1);
        run(3'd3, 2'd1, 16'd3, 16'd0);
        chk("R8 remove on empty", r_sts, 2'd2);
        run(3'd2, 2'd1, 16'd4, 16'd3);
        chk("R8 insert on empty", r_sts, 2'd2);
        ends_are("R8 empty list stays empty", 2'd1, NL, NL);
        run(3'd7, 2'd2, 16'd30, 16'd0);
        chk("R12 reserved op status", r_sts, 2'd3);
        ends_are("R12 ends unchanged", 2'd2, 16'd30, 16'd30);
        link_is("R12 links unchanged", 2'd2, 16'd30, 1'b1, NL);
    endtask

    task automatic t_pairs;
        run(3'd1, 2'd0, 16'd40, 16'd0);
        run(3'd1, 2'd0, 16'd41, 16'd0);
        run(3'd1, 2'd1, 16'd41, 16'd0);
        run(3'd1, 2'd1, 16'd40, 16'd0);
        ends_are("R9 list0 ends", 2'd0, 16'd40, 16'd41);
        ends_are("R9 list1 ends", 2'd1, 16'd41, 16'd40);
        link_is("R9 list0 next", 2'd0, 16'd40, 1'b0, 16'd41);
        link_is("R9 list1 next", 2'd1, 16'd41, 1'b0, 16'd40);
        link_is("R9 list0 prev", 2'd0, 16'd40, 1'b1, NL);
        link_is("R9 list1 prev", 2'd1, 16'd40, 1'b1, 16'd41);
        link_is("R9 list3 untouched", 2'd3, 16'd33, 1'b0, NL);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        cmd_valid = 1'b0;
        cmd_op = 3'd0; cmd_list = 2'd0; cmd_node = 16'd0; cmd_ref = 16'd0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_push_head;
        t_push_tail;
        t_insert_after;
        t_walk;
        t_remove;
        t_errors;
        t_pairs;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule